// File: doc/BRIEF.md
# Self-timed click line receiver

This block turns activity on a single shared wire into bytes. The wire idles high, and a sender marks events on it by pulling it low briefly. Each such pulse is a click, and a click is recognised by its falling edge. The receiver has no preset bit rate. Every byte opens with two start clicks, and the gap between them calibrates the timing for that byte. Each of the eight data bits then occupies two slots, and the click falls in one of them. A click in the early slot means 1. A click in the late slot means 0.

The receiver compares each data-bit delay with one and a half times the calibrated gap. After an early click it waits out the empty second slot, so the next measurement starts in step with the sender. Once the eighth bit is in, the receiver follows the two stop clicks level by level. Only then does it present the byte with a one-cycle strobe.

If any wait runs long enough to fill its counter, the byte is abandoned. A timeout pulse is raised with the data cleared.

Top module: `click_rx`

## Requirements
- R1: After reset `data_o` is 0, and both `valid_o` and `timeout_o` are low.
- R2: `line_i` passes through a two-flop synchroniser. Only a high-to-low transition of the synchronised line counts as a click. In idle, a click begins reception of a byte.
- R3: For `SETTLE_CYC` cycles after the click that opens the byte, and after every data-bit click, further falling edges are ignored and do not disturb the decoded byte.
- R4: After the settle window that follows the first start click, the receiver counts cycles until the second start click. This count is the span S, and it is learned anew for every byte.
- R5: After the settle window, each data bit counts cycles until the next click, giving a count C. The bit is 1 when 2·C < 3·S, otherwise 0.
- R6: After a 1 bit the receiver idles for S more cycles before the next settle window, so a run of 1 bits decodes correctly.
- R7: The first data bit received becomes bit 0 of `data_o`, and the eighth becomes bit 7.
- R8: If a count reaches 2^CNT_W−1 while waiting for a start or data click, reception aborts. `timeout_o` pulses for one cycle, `data_o` becomes 0, `valid_o` stays low, and the receiver returns to idle.
- R9: After the eighth bit the receiver waits for the synchronised line to be high, low, high, low, high in turn, with no time limit. Only then does `valid_o` pulse for one cycle with the byte on `data_o`, which holds until the next result.
- R10: After a result the receiver returns to idle and accepts the next byte, even when that byte starts right after the last stop click.

Both `valid_o` and `timeout_o` are cleared by reset: they are one-cycle pulses, while `data_o` keeps its value until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Click line, asynchronous, idles high |
| data_o | output | 8 | Last decoded byte, or 0 after a timeout |
| valid_o | output | 1 | One-cycle strobe when a byte completes |
| timeout_o | output | 1 | One-cycle strobe when a reception aborts |

## Verification
The bench sends a set of fixed bytes:

- 0x01 and 0x80 show that the bit order is right.
- 0x00 and 0xFF separate the late-click path from the early-click path with its skip. A run of 1 bits fails if the skip is too short.
- Slot periods from 24 to 80 cycles, together with randomly chosen bytes, show that the span really is relearned for each byte rather than fixed.

Several cases target single mechanisms:

- A stray click inside the first settle window must leave the byte unchanged.
- A lone start click, and a byte that stops after three bits, must each end in a timeout with cleared data.
- A byte whose stop clicks are withheld must give no strobe until they arrive.
- Bytes sent back to back show that the receiver returns to idle promptly.

// File: rtl/click_rx_pkg.sv
package click_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAL_SETTLE,
    ST_CAL,
    ST_BIT_SETTLE,
    ST_BIT,
    ST_SKIP,
    ST_STOP
  } rx_state_t;

  // Early-click decision: the bit is 1 when twice the measured delay
  // is below three times the calibrated span.
  function automatic logic click_is_early(input int unsigned meas,
                                          input int unsigned span);
    return (2 * meas) < (3 * span);
  endfunction

  // Level expected on the line in a given stop-following stage:
  // even stages want high, odd stages want low.
  function automatic logic stop_level(input logic [2:0] stage);
    return ~stage[0];
  endfunction

endpackage

// File: rtl/click_sync.sv
module click_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] pipe;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= 1'b1;
    else        pipe[0] <= line_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[g] <= 1'b1;
      else        pipe[g] <= pipe[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= pipe[STAGES-1];
  end

  assign level_o = pipe[STAGES-1];
  assign fall_o  = prev & ~pipe[STAGES-1];
endmodule

// File: rtl/click_timer.sv
module click_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (inc)    cnt <= cnt + 1'b1;
  end

  assign full = &cnt;
endmodule

// File: rtl/click_shift.sv
module click_shift #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             bit_in,
  output logic [NBITS-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   word <= '0;
    else if (clr) word <= '0;
    else if (en)  word <= {bit_in, word[NBITS-1:1]};
  end
endmodule

// File: rtl/click_rx_fsm.sv
module click_rx_fsm
  import click_rx_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int NBITS      = 8,
  parameter int SETTLE_CYC = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall,
  input  logic             level,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cnt_full,
  output logic             tmr_clr,
  output logic             tmr_inc,
  output logic             shift_clr,
  output logic             take_bit,
  output logic             bit_one,
  output logic             done_evt,
  output logic             abort_evt,
  output logic             waiting,
  output logic             in_skip,
  output logic [CNT_W-1:0] span
);
  localparam int BITS_W = $clog2(NBITS + 1);
  localparam logic [CNT_W-1:0]  SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [BITS_W-1:0] LAST_BIT    = BITS_W'(NBITS - 1);
  localparam logic [BITS_W-1:0] ALL_BITS    = BITS_W'(NBITS);

  rx_state_t         state, state_n;
  logic [BITS_W-1:0] nbits;
  logic [2:0]        stage;
  logic              span_ld, stage_inc, skip_end;
  logic [CNT_W:0]    cnt_p1;

  assign cnt_p1   = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign skip_end = cnt_p1 >= {1'b0, span};
  assign waiting  = (state == ST_CAL) || (state == ST_BIT);
  assign in_skip  = (state == ST_SKIP);
  assign bit_one  = click_is_early(32'(cnt), 32'(span));

  always_comb begin
    state_n   = state;
    tmr_clr   = 1'b0;
    tmr_inc   = 1'b0;
    shift_clr = 1'b0;
    take_bit  = 1'b0;
    done_evt  = 1'b0;
    abort_evt = 1'b0;
    span_ld   = 1'b0;
    stage_inc = 1'b0;
    unique case (state)
      ST_IDLE: begin
        tmr_clr = 1'b1;
        if (fall) begin
          shift_clr = 1'b1;
          state_n   = ST_CAL_SETTLE;
        end
      end
      ST_CAL_SETTLE, ST_BIT_SETTLE: begin
        tmr_inc = 1'b1;
        if (cnt == SETTLE_LAST) begin
          tmr_clr = 1'b1;
          state_n = (state == ST_CAL_SETTLE) ? ST_CAL : ST_BIT;
        end
      end
      ST_CAL: begin
        if (fall) begin
          span_ld = 1'b1;
          tmr_clr = 1'b1;
          state_n = ST_BIT_SETTLE;
        end else if (cnt_full) begin
          abort_evt = 1'b1;
          state_n   = ST_IDLE;
        end else begin
          tmr_inc = 1'b1;
        end
      end
      ST_BIT: begin
        if (fall) begin
          take_bit = 1'b1;
          tmr_clr  = 1'b1;
          if (bit_one)               state_n = ST_SKIP;
          else if (nbits == LAST_BIT) state_n = ST_STOP;
          else                       state_n = ST_BIT_SETTLE;
        end else if (cnt_full) begin
          abort_evt = 1'b1;
          state_n   = ST_IDLE;
        end else begin
          tmr_inc = 1'b1;
        end
      end
      ST_SKIP: begin
        tmr_inc = 1'b1;
        if (skip_end) begin
          tmr_clr = 1'b1;
          state_n = (nbits == ALL_BITS) ? ST_STOP : ST_BIT_SETTLE;
        end
      end
      ST_STOP: begin
        if (level == stop_level(stage)) begin
          if (stage == 3'd4) begin
            done_evt = 1'b1;
            state_n  = ST_IDLE;
          end else begin
            stage_inc = 1'b1;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      span  <= '0;
      nbits <= '0;
      stage <= '0;
    end else begin
      state <= state_n;
      if (span_ld) span <= cnt;
      if (state == ST_IDLE)  nbits <= '0;
      else if (take_bit)     nbits <= nbits + 1'b1;
      if (state != ST_STOP)  stage <= '0;
      else if (stage_inc)    stage <= stage + 1'b1;
    end
  end
endmodule

// File: rtl/click_rx.sv
module click_rx #(
  parameter int CNT_W      = 8,
  parameter int SETTLE_CYC = 5,
  parameter int SYNC_STG   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_i,
  output logic [7:0] data_o,
  output logic       valid_o,
  output logic       timeout_o
);
  localparam int NBITS = 8;

  logic             line_lvl, line_fall;
  logic [CNT_W-1:0] cnt, span;
  logic             meas_full, tmr_clr, tmr_inc, shift_clr;
  logic             take_bit, bit_one, done_evt, abort_evt, waiting, in_skip;
  logic [NBITS-1:0] shreg;

  click_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_i(line_i),
    .level_o(line_lvl), .fall_o(line_fall)
  );

  click_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .inc(tmr_inc),
    .cnt(cnt), .full(meas_full)
  );

  click_shift #(.NBITS(NBITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(shift_clr), .en(take_bit),
    .bit_in(bit_one), .word(shreg)
  );

  click_rx_fsm #(.CNT_W(CNT_W), .NBITS(NBITS), .SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .fall(line_fall), .level(line_lvl),
    .cnt(cnt), .cnt_full(meas_full), .tmr_clr(tmr_clr), .tmr_inc(tmr_inc),
    .shift_clr(shift_clr), .take_bit(take_bit), .bit_one(bit_one),
    .done_evt(done_evt), .abort_evt(abort_evt), .waiting(waiting),
    .in_skip(in_skip), .span(span)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o    <= '0;
      valid_o   <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      valid_o   <= done_evt;
      timeout_o <= abort_evt;
      if (done_evt)       data_o <= shreg;
      else if (abort_evt) data_o <= '0;
    end
  end
endmodule

// File: rtl/click_rx_chk.sv
module click_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] data_o,
  input logic       valid_o,
  input logic       timeout_o,
  input logic       line_lvl,
  input logic       line_fall,
  input logic       take_bit,
  input logic       bit_one,
  input logic       meas_full,
  input logic       waiting,
  input logic       in_skip
);
  assert_results_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && timeout_o));

  assert_timeout_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (data_o == 8'h00));

  assert_full_aborts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && meas_full && !line_fall) |=> timeout_o);

  assert_bit_needs_click_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_bit |-> line_fall);

  assert_one_skips_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_bit && bit_one) |=> in_skip);

  assert_zero_no_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_bit && !bit_one) |=> !in_skip);

  assert_valid_after_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(line_lvl));

  assert_data_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && !timeout_o) |-> $stable(data_o));
endmodule

bind click_rx click_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .data_o(data_o), .valid_o(valid_o),
  .timeout_o(timeout_o), .line_lvl(line_lvl), .line_fall(line_fall),
  .take_bit(take_bit), .bit_one(bit_one), .meas_full(meas_full),
  .waiting(waiting), .in_skip(in_skip)
);

// File: tb/test_click_rx.sv
`timescale 1ns/1ps
module test_click_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line = 1'b1;
  logic [7:0] data_o;
  logic       valid_o, timeout_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int vcnt = 0, tcnt = 0;
  logic [7:0] got [0:255];
  logic [7:0] tdata;
  bit done = 1'b0;

  always #4 clk = ~clk;

  click_rx i_click_rx (
    .clk(clk), .rst_n(rst_n), .line_i(line),
    .data_o(data_o), .valid_o(valid_o), .timeout_o(timeout_o)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (valid_o) begin got[vcnt[7:0]] = data_o; vcnt = vcnt + 1; end
    if (timeout_o) begin tdata = data_o; tcnt = tcnt + 1; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Decoded value the sender intends: slot pattern carries the byte LSB first.
  function automatic logic [7:0] expect_byte(input logic [7:0] b);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) r[i] = b[i];
    return r;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic slot(input bit on, input int p, input int w);
    if (on) begin
      line = 1'b0; wait_cyc(w);
      line = 1'b1; wait_cyc(p - w);
    end else wait_cyc(p);
  endtask

  task automatic send_head(input logic [7:0] b, input int p, input int w, input int nb);
    slot(1, p, w); slot(1, p, w);
    for (int i = 0; i < nb; i++) begin
      slot(b[i], p, w); slot(!b[i], p, w);
    end
  endtask

  task automatic send_stop(input int p, input int w);
    slot(1, p, w); slot(1, p, w);
  endtask

  task automatic send_check(input logic [7:0] b, input int p, input int w, input string req);
    int v0 = vcnt, t0 = tcnt;
    send_head(b, p, w, 8); send_stop(p, w); wait_cyc(12);
    check(vcnt == v0 + 1 && tcnt == t0, req, vcnt - v0, 1);
    check(got[v0[7:0]] == expect_byte(b), req, got[v0[7:0]], expect_byte(b));
  endtask

  initial begin
    while (cyc < 150000 && !done) @(negedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int v0, t0;
    void'($urandom(32'h00C1_1C4B));
    wait_cyc(3); rst_n = 1'b1; wait_cyc(2);
    // R1 reset state
    check(data_o == 8'h00 && !valid_o && !timeout_o, "R1", {data_o, valid_o, timeout_o}, 0);

    // R7 bit order, R5 both classes, R6 run of ones, R2 start on falling edge
    send_check(8'h01, 30, 2, "R7");
    send_check(8'h80, 30, 2, "R7");
    send_check(8'h00, 28, 1, "R5");
    send_check(8'hFF, 28, 1, "R6");
    send_check(8'hA5, 24, 3, "R2");
    send_check(8'h5A, 80, 2, "R4");

    // R3 stray click inside the opening settle window
    v0 = vcnt;
    line = 1'b0; wait_cyc(2); line = 1'b1; wait_cyc(1);
    line = 1'b0; wait_cyc(1); line = 1'b1; wait_cyc(36);
    slot(1, 40, 2);
    for (int i = 0; i < 8; i++) begin slot(8'h3C >> i & 1, 40, 2); slot(!(8'h3C >> i & 1), 40, 2); end
    send_stop(40, 2); wait_cyc(12);
    check(vcnt == v0 + 1 && got[v0[7:0]] == 8'h3C, "R3", got[v0[7:0]], 8'h3C);

    // R8 lone start click
    v0 = vcnt; t0 = tcnt;
    slot(1, 30, 2); wait_cyc(400);
    check(tcnt == t0 + 1 && vcnt == v0, "R8", tcnt - t0, 1);
    check(tdata == 8'h00 && data_o == 8'h00, "R8", data_o, 0);

    // R8 abort mid-byte after a good byte
    send_check(8'hC3, 32, 2, "R10");
    v0 = vcnt; t0 = tcnt;
    send_head(8'h07, 32, 2, 3); wait_cyc(700);
    check(tcnt == t0 + 1 && vcnt == v0, "R8", tcnt - t0, 1);
    check(data_o == 8'h00, "R8", data_o, 0);

    // R9 stop clicks withheld
    v0 = vcnt; t0 = tcnt;
    send_head(8'h6E, 30, 2, 8); wait_cyc(600);
    check(vcnt == v0 && tcnt == t0, "R9", vcnt - v0, 0);
    send_stop(30, 2); wait_cyc(12);
    check(vcnt == v0 + 1 && got[v0[7:0]] == 8'h6E, "R9", got[v0[7:0]], 8'h6E);

    // R10 back to back
    v0 = vcnt;
    send_head(8'h96, 26, 1, 8); send_stop(26, 1);
    send_head(8'h69, 26, 1, 8); send_stop(26, 1); wait_cyc(12);
    check(vcnt == v0 + 2, "R10", vcnt - v0, 2);
    check(got[v0[7:0]] == 8'h96 && got[8'(v0 + 1)] == 8'h69, "R10", got[8'(v0 + 1)], 8'h69);

    // R4/R5/R7 random bytes at random rates
    for (int k = 0; k < 24; k++) begin
      logic [7:0] b = 8'($urandom);
      int p = 24 + int'($urandom % 57);
      int w = 1 + int'($urandom % 3);
      send_check(b, p, w, "R4");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule